// File: doc/BRIEF.md
# UART FIFO Ready-Pin Generator

This block drives the two active-low readiness pins of one UART channel: one tells an external block-transfer engine that the transmit side can take data, the other that the receive side has data to hand over. It looks at the FIFO-enable and block-mode control bits, the transmit and receive FIFO fill levels (each FIFO is 128 entries deep), the programmed receive trigger level, a one-cycle receive timeout event, and the two holding-register flags that matter when the FIFOs are switched off. It does not contain the FIFOs or the timeout counter.

Three modes exist. With the FIFOs off, each pin follows its holding register. With the FIFOs on and block mode off, each pin follows its FIFO level. With block mode on, the receive pin becomes an edge-defined state: it asserts on a trigger or timeout event and releases only when the FIFO drains. The transmit pin then stays asserted while any slot is free.

Both pins come from flip-flops. Each pin reflects the inputs sampled at the previous rising clock edge. These are plain status pins. No data passes through the block, so it has no valid/ready handshake and applies no back-pressure. A consumer may read the pins every cycle.

Top module: `uart_rdy_pins`

## Requirements
- R1: While reset is asserted, both txrdy_n and rxrdy_n are 1.
- R2: With fifo_en = 0, rxrdy_n after an edge equals the inverse of rx_hold_full sampled at that edge.
- R3: With fifo_en = 0, txrdy_n after an edge equals tx_hold_full sampled at that edge.
- R4: With fifo_en = 1 and blk_mode = 0, rxrdy_n becomes 0 when rx_level is non-zero and 1 when it is zero.
- R5: With fifo_en = 1 and blk_mode = 0, txrdy_n becomes 0 only when tx_level is zero, and 1 otherwise.
- R6: In block mode (fifo_en = 1, blk_mode = 1), a non-empty receive FIFO with rx_level greater than or equal to rx_trig, or with rx_tmo = 1, drives rxrdy_n to 0. A level that jumps past the trigger counts.
- R7: In block mode, rx_level = 0 drives rxrdy_n to 1, and this wins over a simultaneous timeout or trigger match.
- R8: In block mode, with a non-empty FIFO below the trigger and no timeout, rxrdy_n keeps its previous value.
- R9: In block mode, txrdy_n becomes 0 while tx_level is below 128 and 1 when it equals 128.
- R10: The effective mode is one of three: holding-register (fifo_en = 0), FIFO (fifo_en = 1, blk_mode = 0) or block (both 1). On the edge where the effective mode differs from the one seen at the previous edge, both pins become 1. From the next edge on, they are evaluated under the new mode.
- R11: While fifo_en = 0, changes of blk_mode have no effect on either pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO enable control bit |
| blk_mode | input | 1 | Block-transfer mode control bit |
| tx_hold_full | input | 1 | Transmit holding register holds a byte (FIFOs off) |
| rx_hold_full | input | 1 | Receive holding register holds a byte (FIFOs off) |
| tx_level | input | 8 | Transmit FIFO fill level, 0 to 128 |
| rx_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| rx_trig | input | 8 | Receive trigger level |
| rx_tmo | input | 1 | Receive timeout event, one cycle |
| txrdy_n | output | 1 | Transmit ready, active low |
| rxrdy_n | output | 1 | Receive ready, active low |

## Verification
The properties assume that both level inputs stay within 0 to 128. They also assume every input is settled at each rising edge, because the pins are judged against the values sampled one edge earlier. The random stimulus draws levels only from that range, biased toward 0, 128 and the trigger and its neighbour. It changes inputs only on the falling edge. The properties also assume that a mode change is judged against the mode seen at the previous edge. For this reason they stay silent on the first edge after reset and on the edge of a change, which the mode-switch property covers separately.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_FIFO  = 2'd1,
    MODE_BLOCK = 2'd2
  } rdy_mode_e;

  function automatic rdy_mode_e decode_mode(input logic fifo_en, input logic blk_mode);
    if (!fifo_en)     return MODE_HOLD;
    else if (blk_mode) return MODE_BLOCK;
    else              return MODE_FIFO;
  endfunction
endpackage

// File: rtl/uart_rdy_mode.sv
module uart_rdy_mode
  import uart_rdy_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en,
  input  logic      blk_mode,
  output rdy_mode_e mode,
  output logic      mode_chg
);
  rdy_mode_e mode_q;

  assign mode     = decode_mode(fifo_en, blk_mode);
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_HOLD;
    else        mode_q <= mode;
  end
endmodule

// File: rtl/uart_rdy_tx.sv
module uart_rdy_tx
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rdy_mode_e        mode,
  input  logic             mode_chg,
  input  logic             hold_full,
  input  logic [LVL_W-1:0] level,
  output logic             rdy_n
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_HOLD:  nxt = hold_full;
      MODE_FIFO:  nxt = (level != '0);
      MODE_BLOCK: nxt = (level >= FULL_LVL);
      default:    nxt = 1'b1;
    endcase
    if (mode_chg) nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_n <= 1'b1;
    else        rdy_n <= nxt;
  end
endmodule

// File: rtl/uart_rdy_rx.sv
module uart_rdy_rx
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rdy_mode_e        mode,
  input  logic             mode_chg,
  input  logic             hold_full,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  input  logic             tmo,
  output logic             rdy_n
);
  logic empty, fire, blk_nxt, nxt;

  assign empty = (level == '0);
  assign fire  = (level >= trig) || tmo;

  // block mode: draining wins over a trigger or timeout event
  always_comb begin
    if (empty)     blk_nxt = 1'b1;
    else if (fire) blk_nxt = 1'b0;
    else           blk_nxt = rdy_n;
  end

  always_comb begin
    unique case (mode)
      MODE_HOLD:  nxt = ~hold_full;
      MODE_FIFO:  nxt = empty;
      MODE_BLOCK: nxt = blk_nxt;
      default:    nxt = 1'b1;
    endcase
    if (mode_chg) nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_n <= 1'b1;
    else        rdy_n <= nxt;
  end
endmodule

// File: rtl/uart_rdy_pins.sv
module uart_rdy_pins
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             blk_mode,
  input  logic             tx_hold_full,
  input  logic             rx_hold_full,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_tmo,
  output logic             txrdy_n,
  output logic             rxrdy_n
);
  rdy_mode_e mode;
  logic      mode_chg;

  uart_rdy_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .blk_mode (blk_mode),
    .mode     (mode),
    .mode_chg (mode_chg)
  );

  uart_rdy_tx #(.DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .hold_full (tx_hold_full),
    .level     (tx_level),
    .rdy_n     (txrdy_n)
  );

  uart_rdy_rx #(.DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .hold_full (rx_hold_full),
    .level     (rx_level),
    .trig      (rx_trig),
    .tmo       (rx_tmo),
    .rdy_n     (rxrdy_n)
  );
endmodule

// File: rtl/uart_rdy_pins_chk.sv
module uart_rdy_pins_chk #(
  parameter int DEPTH = 128,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             blk_mode,
  input logic             tx_hold_full,
  input logic             rx_hold_full,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] rx_trig,
  input logic             rx_tmo,
  input logic             txrdy_n,
  input logic             rxrdy_n
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [1:0] eff_now, eff_d;
  logic       rst_d, steady, in_hold, in_fifo, in_blk;

  assign eff_now = !fifo_en ? 2'd0 : (blk_mode ? 2'd2 : 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_d <= 2'd0;
      rst_d <= 1'b0;
    end else begin
      eff_d <= eff_now;
      rst_d <= 1'b1;
    end
  end

  assign steady  = rst_d && (eff_now == eff_d);
  assign in_hold = steady && (eff_now == 2'd0);
  assign in_fifo = steady && (eff_now == 2'd1);
  assign in_blk  = steady && (eff_now == 2'd2);

  AST_HOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |=> (rxrdy_n == !$past(rx_hold_full)));                  // R2
  AST_HOLD_TX: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |=> (txrdy_n == $past(tx_hold_full)));                   // R3
  AST_FIFO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    in_fifo |=> (rxrdy_n == ($past(rx_level) == '0)));               // R4
  AST_FIFO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    in_fifo |=> (txrdy_n == ($past(tx_level) != '0)));               // R5
  AST_BLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk && rx_level != '0 && (rx_level >= rx_trig || rx_tmo)) |=> !rxrdy_n); // R6
  AST_BLK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk && rx_level == '0) |=> rxrdy_n);                         // R7
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk && rx_level != '0 && rx_level < rx_trig && !rx_tmo) |=> $stable(rxrdy_n)); // R8
  AST_BLK_TX: assert property (@(posedge clk) disable iff (!rst_n)
    in_blk |=> (txrdy_n == ($past(tx_level) >= FULL_LVL)));          // R9
  AST_MODE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_d && eff_now != eff_d) |=> (txrdy_n && rxrdy_n));           // R10
endmodule

bind uart_rdy_pins uart_rdy_pins_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .blk_mode     (blk_mode),
  .tx_hold_full (tx_hold_full),
  .rx_hold_full (rx_hold_full),
  .tx_level     (tx_level),
  .rx_level     (rx_level),
  .rx_trig      (rx_trig),
  .rx_tmo       (rx_tmo),
  .txrdy_n      (txrdy_n),
  .rxrdy_n      (rxrdy_n)
);

// File: tb/sim_uart_rdy_pins.sv
module sim_uart_rdy_pins;
  localparam int CLK_P = 10;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, blk_mode = 1'b0;
  logic       tx_hold_full = 1'b0, rx_hold_full = 1'b0, rx_tmo = 1'b0;
  logic [7:0] tx_level = '0, rx_level = '0, rx_trig = 8'd16;
  logic       txrdy_n, rxrdy_n;

  int checks = 0;
  int fails  = 0;

  // bench model state
  int   m_mode = 0;
  logic m_rx = 1'b1, m_tx = 1'b1, m_blk = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_rdy_pins #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
    .tx_hold_full(tx_hold_full), .rx_hold_full(rx_hold_full),
    .tx_level(tx_level), .rx_level(rx_level), .rx_trig(rx_trig),
    .rx_tmo(rx_tmo), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  function automatic int eff_mode(input logic fe, input logic bm);
    return !fe ? 0 : (bm ? 2 : 1);
  endfunction

  task automatic chk(input string tag, input string pin, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, pin, act, exp);
    end
  endtask

  // one clock: predict from the requirements, advance, compare at negedge
  task automatic step();
    int   e;
    logic erx, etx;
    string trx, ttx;
    e = eff_mode(fifo_en, blk_mode);
    if (e != m_mode) begin
      erx = 1'b1; etx = 1'b1; trx = "R10"; ttx = "R10";
    end else if (e == 0) begin
      erx = !rx_hold_full; etx = tx_hold_full;
      trx = (blk_mode != m_blk) ? "R11" : "R2";
      ttx = (blk_mode != m_blk) ? "R11" : "R3";
    end else if (e == 1) begin
      erx = (rx_level == 0); etx = (tx_level != 0); trx = "R4"; ttx = "R5";
    end else begin
      etx = (tx_level >= DEPTH); ttx = "R9";
      if (rx_level == 0) begin erx = 1'b1; trx = "R7"; end
      else if (rx_level >= rx_trig || rx_tmo) begin erx = 1'b0; trx = "R6"; end
      else begin erx = m_rx; trx = "R8"; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(trx, "rxrdy_n", rxrdy_n, erx);
    chk(ttx, "txrdy_n", txrdy_n, etx);
    m_mode = e; m_rx = erx; m_tx = etx; m_blk = blk_mode;
  endtask

  task automatic drive(input logic fe, input logic bm, input logic rh, input logic th,
                       input int rl, input int tl, input logic tmo);
    fifo_en = fe; blk_mode = bm; rx_hold_full = rh; tx_hold_full = th;
    rx_level = 8'(rl); tx_level = 8'(tl); rx_tmo = tmo;
    step();
  endtask

  function automatic int pick_level(input int unsigned r, input int trig);
    case (r % 8)
      0: return 0;
      1: return DEPTH;
      2: return trig;
      3: return (trig > 0) ? trig - 1 : 0;
      default: return int'((r >> 3) % (DEPTH + 1));
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h2bd5);
    repeat (3) @(negedge clk);
    chk("R1", "rxrdy_n", rxrdy_n, 1'b1);
    chk("R1", "txrdy_n", txrdy_n, 1'b1);
    rst_n = 1'b1;

    // holding-register mode
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0, 0);
    drive(0, 0, 1, 1, 0, 0, 0);
    // R11: blk_mode toggles while FIFOs are off
    drive(0, 1, 1, 1, 0, 0, 0);
    drive(0, 0, 1, 1, 50, 128, 1);
    // FIFO mode: mode switch then levels
    drive(1, 0, 0, 0, 5, 5, 0);
    drive(1, 0, 0, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0, 128, 0);
    drive(1, 0, 0, 0, 128, 1, 0);
    // block mode, trigger 16
    rx_trig = 8'd16;
    drive(1, 1, 0, 0, 20, 127, 0);   // R10 switch
    drive(1, 1, 0, 0, 5, 127, 0);    // R8 hold at 1
    drive(1, 1, 0, 0, 16, 128, 0);   // R6 exact trigger
    drive(1, 1, 0, 0, 9, 0, 0);      // R8 hold at 0
    drive(1, 1, 0, 0, 0, 0, 0);      // R7 drain
    drive(1, 1, 0, 0, 40, 0, 0);     // R6 jump past trigger
    drive(1, 1, 0, 0, 0, 0, 1);      // R7 empty beats timeout
    drive(1, 1, 0, 0, 3, 0, 1);      // R6 timeout
    drive(1, 1, 0, 0, 2, 0, 0);      // R8 hold at 0

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic fe, bm;
      r = $urandom;
      fe = fifo_en; bm = blk_mode;
      if (r % 16 == 0) begin fe = r[4]; bm = r[5]; end
      if (r % 64 == 1) rx_trig = 8'((r >> 8) % DEPTH + 1);
      drive(fe, bm, r[6], r[7], pick_level($urandom, int'(rx_trig)),
            pick_level($urandom, DEPTH), (r[12:10] == 3'd0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule